// File: doc/BRIEF.md
# NAND Flash Bus Bridge

This block connects a 16-bit host memory request stream to up to two 8-bit NAND flash slots and a small local register window. The host presents one request at a time as a valid/ready transfer. Address bits 24..22 of the request pick the target: one of the flash slots, the local window, or nothing. The low address bits then steer the flash command-latch and address-latch lines for that data cycle. No separate control register is involved: software reaches command, address and data cycles by choosing the offset it uses.

Each access runs one fixed cycle. The chip enable falls, then the read or write strobe is held low for a set number of clocks. After that the chip enable and the write data stay driven through a hold interval, which gives the flash more than 9 ns of data hold at 125 MHz. Every access returns one response beat. Read data sits in the low byte for flash reads and in bit 0 for the status register. The status register reports the synchronized ready/busy level of the slot that the most recent flash access selected.

Back-pressure rules: `req_ready` is high only while the bridge is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` stays high with `rsp_rdata` unchanged until a clock edge where `rsp_ready` is high. The next request is accepted only after that edge.

Top module: `nand_bus_bridge`

## Requirements
- R1: Address bits 24..22 equal to 3'b010 target slot 0 (`nand_ce_n[0]`), 3'b011 target slot 1 (`nand_ce_n[1]`), and 3'b100 the local window. No more than one chip enable is low at any time. A local or undecoded access lowers no chip enable.
- R2: During a flash access, `nand_cle` equals request address bit 5 and `nand_ale` equals request address bit 4. Both are low at all other times.
- R3: A flash access holds the chip enable low for SETUP_CLKS (1) clock before the strobe goes low. The strobe stays low for exactly STROBE_CLKS (4) clocks. The chip enable stays low for HOLD_CLKS (2) clocks after the strobe rises.
- R4: A flash write pulses only `nand_we_n`. `nand_dq_out` carries request data bits 7..0, and `nand_dq_oe` is high through the strobe and hold clocks. `nand_we_n` and `nand_re_n` are never low together.
- R5: A flash read pulses only `nand_re_n`, leaves `nand_dq_oe` low, and returns `{8'h00, nand_dq_in}` as sampled in the last strobe clock.
- R6: A read at local offset 8'h02 returns bit 0 as 1 when the synchronized `nand_ready` of the last selected slot is high, and as 0 when it is low. Bits 15..1 read as 0. After reset, slot 0 is the selected slot. The pin passes through two flops.
- R7: Reads of undecoded addresses, or of local offsets other than 8'h02, return 16'h0000. Writes to such addresses, and writes to the local window, have no effect. Both kinds take the same number of clocks as a flash access.
- R8: `req_ready` is high only when idle. `rsp_valid` stays high and `rsp_rdata` stays stable until `rsp_ready` is high. From acceptance, the response appears after SETUP_CLKS+STROBE_CLKS+HOLD_CLKS clocks.
- R9: During and right after reset, all chip enables and strobes are high, `nand_dq_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Host byte address |
| req_wdata | input | 16 | Write data (low byte goes to flash) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 16 | Read data (0 for writes) |
| nand_ce_n | output | 2 | Per-slot chip enable, active low |
| nand_cle | output | 1 | Command-latch enable |
| nand_ale | output | 1 | Address-latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data driven to flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Data from flash |
| nand_ready | input | 2 | Per-slot ready (1) / busy (0), asynchronous |

## Verification
A corrupted target latch shows at once as a chip enable on the wrong slot, or as a strobe during a local access. The next access observed at the pins exposes it. A phase counter that slips shows within the same access as a strobe that is not four clocks long, a chip enable that rises early, or a response that is a clock off from the expected latency. A stale selected-slot register only shows on the next status read, so the bench reads status right after switching slots.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RESP} phase_e;
  typedef enum logic [1:0] {TGT_NONE, TGT_SLOT, TGT_LOCAL} tgt_kind_e;
  localparam logic [2:0] SEL_SLOT_BASE = 3'b010;
  localparam logic [2:0] SEL_LOCAL     = 3'b100;
endpackage

// File: rtl/nbb_decode.sv
module nbb_decode
  import nbb_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int OFS_W     = 8,
  parameter int STAT_OFS  = 2,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [2:0]       sel,
  input  logic [OFS_W-1:0] ofs,
  output tgt_kind_e        kind,
  output logic [SLOT_W-1:0] slot,
  output logic             stat_hit
);
  always_comb begin
    kind = TGT_NONE;
    slot = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (sel == SEL_SLOT_BASE + 3'(i)) begin
        kind = TGT_SLOT;
        slot = SLOT_W'(i);
      end
    end
    if (sel == SEL_LOCAL) kind = TGT_LOCAL;
    stat_hit = (kind == TGT_LOCAL) && (ofs == OFS_W'(STAT_OFS));
  end
endmodule

// File: rtl/nbb_rb_sync.sv
module nbb_rb_sync #(
  parameter int NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] rdy_async,
  output logic [NUM_SLOTS-1:0] rdy_sync
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sync
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= rdy_async[g];
        sync_q <= meta_q;
      end
    end
    assign rdy_sync[g] = sync_q;
  end
endmodule

// File: rtl/nbb_timing.sv
module nbb_timing
  import nbb_pkg::*;
#(
  parameter int SETUP_CLKS  = 1,
  parameter int STROBE_CLKS = 4,
  parameter int HOLD_CLKS   = 2,
  localparam int MAX_A = (SETUP_CLKS > STROBE_CLKS) ? SETUP_CLKS : STROBE_CLKS,
  localparam int MAXC  = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS,
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   rsp_ready,
  output phase_e phase,
  output logic   last_strobe
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= CNT_W'(SETUP_CLKS - 1);
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_STROBE;
          cnt   <= CNT_W'(STROBE_CLKS - 1);
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          phase <= PH_HOLD;
          cnt   <= CNT_W'(HOLD_CLKS - 1);
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) phase <= PH_RESP;
                 else cnt <= cnt - 1'b1;
        PH_RESP: if (rsp_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign last_strobe = (phase == PH_STROBE) && (cnt == '0);

  // Checker: strobe phase length, measured independently of cnt
  logic [CNT_W:0] strobe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_run <= '0;
    else if (phase == PH_SETUP) strobe_run <= '0;
    else if (phase == PH_STROBE) strobe_run <= strobe_run + 1'b1;
  end

  p_strobe_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |-> (strobe_run == (CNT_W+1)'(STROBE_CLKS)));

  p_setup_to_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE && strobe_run == '0) |-> ($past(phase) == PH_SETUP));
endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
  import nbb_pkg::*;
#(
  parameter int ADDR_W      = 25,
  parameter int DATA_W      = 16,
  parameter int NAND_W      = 8,
  parameter int NUM_SLOTS   = 2,
  parameter int SEL_LSB     = 22,
  parameter int CLE_BIT     = 5,
  parameter int ALE_BIT     = 4,
  parameter int OFS_W       = 8,
  parameter int STAT_OFS    = 2,
  parameter int SETUP_CLKS  = 1,
  parameter int STROBE_CLKS = 4,
  parameter int HOLD_CLKS   = 2,
  localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NUM_SLOTS-1:0] nand_ce_n,
  output logic                 nand_cle,
  output logic                 nand_ale,
  output logic                 nand_we_n,
  output logic                 nand_re_n,
  output logic [NAND_W-1:0]    nand_dq_out,
  output logic                 nand_dq_oe,
  input  logic [NAND_W-1:0]    nand_dq_in,
  input  logic [NUM_SLOTS-1:0] nand_ready
);
  logic unused_req_bits;
  assign unused_req_bits = ^{req_addr, req_wdata};

  tgt_kind_e         dec_kind;
  logic [SLOT_W-1:0] dec_slot;
  logic              dec_stat;

  nbb_decode #(.NUM_SLOTS(NUM_SLOTS), .OFS_W(OFS_W), .STAT_OFS(STAT_OFS)) u_decode (
    .sel      (req_addr[SEL_LSB+2:SEL_LSB]),
    .ofs      (req_addr[OFS_W-1:0]),
    .kind     (dec_kind),
    .slot     (dec_slot),
    .stat_hit (dec_stat)
  );

  logic [NUM_SLOTS-1:0] rdy_sync;
  nbb_rb_sync #(.NUM_SLOTS(NUM_SLOTS)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdy_async (nand_ready),
    .rdy_sync  (rdy_sync)
  );

  phase_e phase;
  logic   last_strobe;
  logic   accept;
  assign accept = req_valid && req_ready;

  nbb_timing #(.SETUP_CLKS(SETUP_CLKS), .STROBE_CLKS(STROBE_CLKS),
               .HOLD_CLKS(HOLD_CLKS)) u_timing (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .rsp_ready   (rsp_ready),
    .phase       (phase),
    .last_strobe (last_strobe)
  );

  // Latched request
  tgt_kind_e         r_kind;
  logic [SLOT_W-1:0] r_slot;
  logic [SLOT_W-1:0] sel_slot;
  logic              r_write, r_cle, r_ale;
  logic [NAND_W-1:0] r_wdata;
  logic [DATA_W-1:0] r_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_kind   <= TGT_NONE;
      r_slot   <= '0;
      sel_slot <= '0;
      r_write  <= 1'b0;
      r_cle    <= 1'b0;
      r_ale    <= 1'b0;
      r_wdata  <= '0;
      r_rdata  <= '0;
    end else if (accept) begin
      r_kind  <= dec_kind;
      r_slot  <= dec_slot;
      r_write <= req_write;
      r_cle   <= req_addr[CLE_BIT];
      r_ale   <= req_addr[ALE_BIT];
      r_wdata <= req_wdata[NAND_W-1:0];
      if (dec_kind == TGT_SLOT) sel_slot <= dec_slot;
      if (dec_stat && !req_write)
        r_rdata <= {{(DATA_W-1){1'b0}}, rdy_sync[sel_slot]};
      else
        r_rdata <= '0;
    end else if (last_strobe && r_kind == TGT_SLOT && !r_write) begin
      r_rdata <= {{(DATA_W-NAND_W){1'b0}}, nand_dq_in};
    end
  end

  logic active, slot_acc, strobe_on;
  assign active    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign slot_acc  = active && (r_kind == TGT_SLOT);
  assign strobe_on = (phase == PH_STROBE) && (r_kind == TGT_SLOT);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_ce
    assign nand_ce_n[g] = !(slot_acc && r_slot == SLOT_W'(g));
  end

  assign nand_we_n   = !(strobe_on && r_write);
  assign nand_re_n   = !(strobe_on && !r_write);
  assign nand_cle    = slot_acc && r_cle;
  assign nand_ale    = slot_acc && r_ale;
  assign nand_dq_out = r_wdata;
  assign nand_dq_oe  = slot_acc && r_write;
  assign req_ready   = (phase == PH_IDLE);
  assign rsp_valid   = (phase == PH_RESP);
  assign rsp_rdata   = r_rdata;

  p_ce_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));
  p_strobe_has_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> (nand_ce_n != '1));
  p_no_dual_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  p_oe_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);
  p_latch_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_ce_n == '1) |-> (!nand_cle && !nand_ale));
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  p_idle_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));
endmodule

// File: tb/tb_nand_bus_bridge.sv
`timescale 1ns/1ps
module tb_nand_bus_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [24:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [1:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = 8'h00;
  logic [1:0]  nand_ready = 2'b00;

  always #4 clk = ~clk;

  nand_bus_bridge dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_ready(nand_ready)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-access pin monitor, sampled on falling edges
  logic       mon_on = 1'b0;
  int         idx, first_ce, last_ce, first_stb, last_stb, we_cnt, re_cnt, dual;
  logic [1:0] ce_seen;
  logic [7:0] stb_dq;
  logic       stb_oe, stb_cle, stb_ale, oe_hold_ok;

  always @(negedge clk) if (mon_on) begin
    idx++;
    if (nand_ce_n != 2'b11) begin
      if (first_ce < 0) first_ce = idx;
      last_ce = idx;
      ce_seen |= ~nand_ce_n;
    end
    if (!nand_we_n || !nand_re_n) begin
      if (first_stb < 0) first_stb = idx;
      last_stb = idx;
      stb_dq = nand_dq_out; stb_oe = nand_dq_oe;
      stb_cle = nand_cle; stb_ale = nand_ale;
    end
    if (!nand_we_n) we_cnt++;
    if (!nand_re_n) re_cnt++;
    if (!nand_we_n && !nand_re_n) dual++;
    if (last_stb > 0 && idx > last_stb && nand_ce_n != 2'b11 && !nand_dq_oe && we_cnt > 0)
      oe_hold_ok = 1'b0;
  end

  task automatic access(input logic wr, input logic [24:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    idx = 0; first_ce = -1; last_ce = -1; first_stb = -1; last_stb = -1;
    we_cnt = 0; re_cnt = 0; dual = 0; ce_seen = 2'b00; oe_hold_ok = 1'b1;
    stb_dq = '0; stb_oe = 1'b0; stb_cle = 1'b0; stb_ale = 1'b0;
    mon_on = 1'b1;
    lat = 0;
    forever begin
      @(negedge clk); #1;
      if (rsp_valid || lat > 50) break;
      lat++;
    end
    rd = rsp_rdata;
    mon_on = 1'b0;
    while (!rsp_ready) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "ce_n in reset", nand_ce_n, 2'b11);
    chk("R9", "strobes in reset", {nand_we_n, nand_re_n}, 2'b11);
    chk("R9", "oe/rsp in reset", {nand_dq_oe, rsp_valid}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "req_ready after reset", req_ready, 1'b1);
  endtask

  task automatic t_slot_write();
    logic [15:0] rd; int lat;
    access(1'b1, 25'h0800020, 16'hA55A, rd, lat);   // slot 0, command cycle
    chk("R1", "slot0 ce seen", ce_seen, 2'b01);
    chk("R2", "cle/ale on cmd", {stb_cle, stb_ale}, 2'b10);
    chk("R3", "setup before strobe", first_stb - first_ce, 1);
    chk("R3", "strobe length", we_cnt, 4);
    chk("R3", "hold after strobe", last_ce - last_stb, 2);
    chk("R4", "write data", stb_dq, 8'h5A);
    chk("R4", "oe during strobe", stb_oe, 1'b1);
    chk("R4", "oe through hold", oe_hold_ok, 1'b1);
    chk("R4", "no read strobe", {re_cnt[7:0], dual[7:0]}, 16'h0);
    chk("R8", "latency", lat, 7);
    access(1'b1, 25'h0C00010, 16'h0033, rd, lat);   // slot 1, address cycle
    chk("R1", "slot1 ce seen", ce_seen, 2'b10);
    chk("R2", "cle/ale on addr", {stb_cle, stb_ale}, 2'b01);
    chk("R4", "write data slot1", stb_dq, 8'h33);
  endtask

  task automatic t_slot_read();
    logic [15:0] rd; int lat;
    nand_dq_in = 8'hC3;
    access(1'b0, 25'h0C00000, 16'h0, rd, lat);
    chk("R5", "read data", rd, 16'h00C3);
    chk("R5", "read strobe only", {we_cnt[7:0], re_cnt[7:0]}, 16'h0004);
    chk("R5", "oe low on read", stb_oe, 1'b0);
    chk("R2", "data cycle latches low", {stb_cle, stb_ale}, 2'b00);
    nand_dq_in = 8'h7E;
    access(1'b0, 25'h0800000, 16'h0, rd, lat);
    chk("R5", "read data slot0", rd, 16'h007E);
  endtask

  task automatic t_status();
    logic [15:0] rd; int lat;
    // last selected slot is slot 0 (from t_slot_read)
    nand_ready = 2'b00; repeat (3) @(negedge clk);
    access(1'b0, 25'h1000002, 16'h0, rd, lat);
    chk("R6", "status busy", rd, 16'h0000);
    chk("R1", "local lowers no ce", ce_seen, 2'b00);
    nand_ready = 2'b01; repeat (3) @(negedge clk);
    access(1'b0, 25'h1000002, 16'h0, rd, lat);
    chk("R6", "status ready slot0", rd, 16'h0001);
    access(1'b1, 25'h0C00000, 16'h0, rd, lat);        // select slot 1
    access(1'b0, 25'h1000002, 16'h0, rd, lat);
    chk("R6", "status follows slot1 busy", rd, 16'h0000);
    nand_ready = 2'b10; repeat (3) @(negedge clk);
    access(1'b0, 25'h1000002, 16'h0, rd, lat);
    chk("R6", "status slot1 ready", rd, 16'h0001);
  endtask

  task automatic t_undecoded();
    logic [15:0] rd; int lat;
    nand_dq_in = 8'hFF;
    access(1'b0, 25'h0000000, 16'h0, rd, lat);
    chk("R7", "undecoded read zero", rd, 16'h0000);
    chk("R7", "undecoded no pins", {ce_seen, we_cnt[7:0], re_cnt[7:0]}, 18'h0);
    chk("R7", "undecoded latency", lat, 7);
    access(1'b1, 25'h1400020, 16'hFFFF, rd, lat);
    chk("R7", "undecoded write no pins", {ce_seen, we_cnt[7:0]}, 10'h0);
    access(1'b0, 25'h1000004, 16'h0, rd, lat);
    chk("R7", "other local offset zero", rd, 16'h0000);
    access(1'b1, 25'h1000002, 16'h0000, rd, lat);
    chk("R7", "local write no ce", ce_seen, 2'b00);
    access(1'b0, 25'h1000002, 16'h0, rd, lat);
    chk("R7", "status unchanged by write", rd, 16'h0001);
  endtask

  task automatic t_backpressure();
    logic [15:0] rd; int lat;
    logic [15:0] first;
    nand_dq_in = 8'h96;
    rsp_ready = 1'b0;
    fork
      access(1'b0, 25'h0800000, 16'h0, rd, lat);
      begin
        wait (rsp_valid); @(negedge clk); #1;
        first = rsp_rdata;
        repeat (4) begin
          @(negedge clk); #1;
          chk("R8", "rsp held", {rsp_valid, req_ready}, 2'b10);
          chk("R8", "rdata stable", rsp_rdata, first);
        end
        rsp_ready = 1'b1;
      end
    join
    chk("R8", "held data value", rd, 16'h0096);
    @(negedge clk);
    chk("R8", "idle after take", {req_ready, rsp_valid}, 2'b10);
  endtask

  logic done = 1'b0;
  initial begin
    t_reset();
    t_slot_write();
    t_slot_read();
    t_status();
    t_undecoded();
    t_backpressure();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule